// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block sits between a flash client and a byte-count-limited SPI shift engine. The client opens a request by giving two lengths: the total number of bytes it will push on the write stream, and the number of bytes it expects back on the read stream. The write stream then carries the command byte, any address bytes (most significant first), an optional dummy byte, and the write data. The sequencer decodes the command and checks that the request is consistent. It then drives the engine with a series of short operations. Each operation carries a command byte, up to three address bytes, and at most four data bytes in one direction only.

A read or a program longer than four bytes is cut into pieces. The address moves forward after every piece by the number of bytes that piece moved. Between program pieces the sequencer polls the flash status register until the busy flag drops, then sends a write-enable before the next piece. A fast-read is sent as a plain read without its dummy byte. A request that cannot be issued is refused: its write bytes are drained and no operation reaches the engine. Every request ends with a single-cycle completion pulse and an error flag.

Top module: `spi_flash_sequencer`

## Requirements
- R1: After reset the block accepts a request (`req_ready`=1), and `op_valid`, `wr_ready`, `rd_valid` and `done` are all 0.
- R2: Commands with fixed data lengths issue one operation with `op_txcnt` = 1 + address bytes + transmit bytes. The required lengths are: 0x06, 0x04, 0xC7 send and receive nothing; 0x9F receives 3; 0x05 receives 1; 0x01 sends 1 data byte; 0xAB takes 3 address bytes and receives 1. The request lengths must match these exactly.
- R3: 0xD8, 0x03, 0x02, 0x0B and 0xAB take 3 address bytes from the write stream, most significant first. Operations for these commands show `op_alen`=3. All other commands use `op_alen`=0 and address 0.
- R4: For 0x0B, the single byte after the address is discarded and every operation is issued with command 0x03.
- R5: The data phase is split into pieces of min(remaining, 4) bytes in each direction. Write byte i of a piece sits in `op_wdata[8i+7:8i]`, and `op_rxcnt` is the piece's receive count.
- R6: Each piece's `op_addr` equals the request address plus all bytes moved by earlier pieces.
- R7: Received bytes leave on the read stream in order. Byte i of a response is `rsp_data[8i+7:8i]`.
- R8: After each 0x02 piece except the last, the block issues 0x05 operations (txcnt 1, rxcnt 1). It repeats them while bit 0 of the returned status is 1, then issues 0x06 (txcnt 1, rxcnt 0), then the next piece.
- R9: A request is refused with `done_err`=1 and no operation issued in any of these cases: zero write length, unknown command, write data and read data together, write length shorter than the header, or fixed-length mismatch. All its write bytes are consumed.
- R10: `done` is high for exactly one cycle per request, with `done_err`=0 on success.
- R11: While `op_valid` waits for `op_ready`, the operation fields hold steady. While `rd_valid` waits for `rd_ready`, `rd_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_wlen | input | LEN_W | Total write-stream bytes of the request |
| req_rlen | input | LEN_W | Read bytes expected |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| op_valid | output | 1 | Operation offered to the engine |
| op_ready | input | 1 | Engine takes the operation |
| op_code | output | 8 | Command byte |
| op_addr | output | 24 | Address |
| op_alen | output | 2 | Address byte count |
| op_wdata | output | 8*PIECE_MAX | Transmit data, byte 0 lowest |
| op_txcnt | output | TCW | Bytes sent: command + address + data |
| op_rxcnt | output | PW | Bytes received |
| rsp_valid | input | 1 | Engine finished the operation |
| rsp_data | input | 8*PIECE_MAX | Received bytes, byte 0 lowest |
| done | output | 1 | Request complete pulse |
| done_err | output | 1 | Request refused |

## Verification
The assertions assume the engine returns exactly one `rsp_valid` pulse for each accepted operation and never sends one unprompted. They also assume a request is offered only while `req_ready` is high. The bench engine model keeps to this. It holds at most one operation in flight, returns its response one to three cycles after acceptance, and throttles `op_ready` and `rd_ready` at random. Requests are sent as single-cycle pulses, and only after the previous completion pulse. The status-bit model answers busy a chosen number of times per poll round.

// File: rtl/sfs_pkg.sv
// Shared command codes, decode record and controller states for the
// flash command sequencer. Assumes 3-byte flash addressing.
package sfs_pkg;
    localparam int ADDR_BYTES = 3;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRDI  = 8'h04;
    localparam logic [7:0] CMD_CHIP  = 8'hC7;
    localparam logic [7:0] CMD_JID   = 8'h9F;
    localparam logic [7:0] CMD_RDST  = 8'h05;
    localparam logic [7:0] CMD_WRST  = 8'h01;
    localparam logic [7:0] CMD_ID    = 8'hAB;
    localparam logic [7:0] CMD_SECT  = 8'hD8;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_FREAD = 8'h0B;

    typedef struct packed {
        logic       known;   // command recognised
        logic [1:0] acnt;    // address bytes
        logic       dummy;   // one byte to drop after address
        logic       prog;    // needs poll + enable between pieces
        logic       fixed;   // lengths must match ftx / frx
        logic [2:0] ftx;
        logic [2:0] frx;
        logic [7:0] issue;   // command byte sent to the engine
    } cmd_info_t;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_PLAN, S_GATHER, S_ISSUE, S_WAIT,
        S_EMIT, S_POLL, S_POLL_WAIT, S_WREN, S_WREN_WAIT, S_DRAIN, S_DONE
    } seq_state_t;
endpackage

// File: rtl/sfs_cmd_decode.sv
// Command decoder: maps a command byte to its address length, dummy byte,
// program flag, fixed data lengths and the byte actually issued.
// Assumes nothing about timing; purely combinational.
module sfs_cmd_decode
    import sfs_pkg::*;
(
    input  logic [7:0] cmd,
    output cmd_info_t  info
);
    // Table lookup of command properties.
    always_comb begin
        info       = '0;
        info.issue = cmd;
        case (cmd)
            CMD_WREN, CMD_WRDI, CMD_CHIP: begin
                info.known = 1'b1; info.fixed = 1'b1;
            end
            CMD_JID: begin
                info.known = 1'b1; info.fixed = 1'b1; info.frx = 3'd3;
            end
            CMD_RDST: begin
                info.known = 1'b1; info.fixed = 1'b1; info.frx = 3'd1;
            end
            CMD_WRST: begin
                info.known = 1'b1; info.fixed = 1'b1; info.ftx = 3'd1;
            end
            CMD_ID: begin
                info.known = 1'b1; info.fixed = 1'b1; info.acnt = 2'd3;
                info.frx = 3'd1;
            end
            CMD_SECT: begin
                info.known = 1'b1; info.fixed = 1'b1; info.acnt = 2'd3;
            end
            CMD_READ: begin
                info.known = 1'b1; info.acnt = 2'd3;
            end
            CMD_PROG: begin
                info.known = 1'b1; info.acnt = 2'd3; info.prog = 1'b1;
            end
            CMD_FREAD: begin
                info.known = 1'b1; info.acnt = 2'd3; info.dummy = 1'b1;
                info.issue = CMD_READ;
            end
            default: info = '0;
        endcase
    end
endmodule

// File: rtl/sfs_piece_size.sv
// Piece sizer: min(remaining, PIECE_MAX). Assumes LEN_W covers PW bits.
module sfs_piece_size #(
    parameter int LEN_W     = 8,
    parameter int PIECE_MAX = 4,
    localparam int PW       = $clog2(PIECE_MAX + 1)
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [PW-1:0]    piece
);
    // Clamp the remaining count to one piece.
    always_comb begin
        if (remaining >= LEN_W'(PIECE_MAX))
            piece = PW'(PIECE_MAX);
        else
            piece = remaining[PW-1:0];
    end
endmodule

// File: rtl/spi_flash_sequencer.sv
// Flash command sequencer. Takes a request (lengths), parses the command
// header from the write stream, and drives a shift engine with operations
// of at most PIECE_MAX data bytes. Between program pieces it polls status
// and re-enables writes. Assumes one engine response per accepted
// operation, and requests only while req_ready is high.
module spi_flash_sequencer
    import sfs_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int PIECE_MAX = 4,
    localparam int DW       = 8 * PIECE_MAX,
    localparam int PW       = $clog2(PIECE_MAX + 1),
    localparam int IW       = $clog2(PIECE_MAX),
    localparam int TCW      = $clog2(ADDR_BYTES + PIECE_MAX + 2),
    localparam int AW       = 8 * ADDR_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LEN_W-1:0] req_wlen,
    input  logic [LEN_W-1:0] req_rlen,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [7:0]       op_code,
    output logic [AW-1:0]    op_addr,
    output logic [1:0]       op_alen,
    output logic [DW-1:0]    op_wdata,
    output logic [TCW-1:0]   op_txcnt,
    output logic [PW-1:0]    op_rxcnt,
    input  logic             rsp_valid,
    input  logic [DW-1:0]    rsp_data,
    output logic             done,
    output logic             done_err
);
    seq_state_t       st;
    cmd_info_t        info_q, dec;
    logic [LEN_W-1:0] wrem, rrem, cnt;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wbuf, rxbuf;
    logic [PW-1:0]    tx_n, rx_n, ptx, prx;
    logic             err;

    sfs_cmd_decode u_dec (.cmd(wr_data), .info(dec));
    sfs_piece_size #(.LEN_W(LEN_W), .PIECE_MAX(PIECE_MAX)) u_tx_piece (.remaining(wrem), .piece(ptx));
    sfs_piece_size #(.LEN_W(LEN_W), .PIECE_MAX(PIECE_MAX)) u_rx_piece (.remaining(rrem), .piece(prx));

    // Header consistency check applied when the command byte arrives.
    logic [LEN_W-1:0] body, hdr, dlen;
    logic             hdr_bad;
    always_comb begin
        body    = wrem - 1'b1;
        hdr     = LEN_W'(dec.acnt) + LEN_W'(dec.dummy);
        dlen    = body - hdr;
        hdr_bad = !dec.known || (body < hdr) || ((dlen != '0) && (rrem != '0))
                  || (dec.fixed && ((dlen != LEN_W'(dec.ftx)) || (rrem != LEN_W'(dec.frx))));
    end

    // Where to go once a data piece has fully completed.
    seq_state_t after_st;
    always_comb begin
        if ((wrem == '0) && (rrem == '0)) after_st = S_DONE;
        else if (info_q.prog)             after_st = S_POLL;
        else                              after_st = S_PLAN;
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; info_q <= '0; wrem <= '0; rrem <= '0; cnt <= '0;
            addr <= '0; wbuf <= '0; rxbuf <= '0; tx_n <= '0; rx_n <= '0; err <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    wrem <= req_wlen; rrem <= req_rlen; addr <= '0; err <= 1'b0;
                    if (req_wlen == '0) begin err <= 1'b1; st <= S_DONE; end
                    else st <= S_OPC;
                end
                S_OPC: if (wr_valid) begin
                    info_q <= dec;
                    if (hdr_bad) begin
                        err <= 1'b1; cnt <= body;
                        st  <= (body == '0) ? S_DONE : S_DRAIN;
                    end else begin
                        wrem <= dlen; cnt <= LEN_W'(dec.acnt);
                        if (dec.acnt != '0)  st <= S_ADDR;
                        else if (dec.dummy)  st <= S_DUMMY;
                        else                 st <= S_PLAN;
                    end
                end
                S_ADDR: if (wr_valid) begin
                    addr <= {addr[AW-9:0], wr_data};
                    cnt  <= cnt - 1'b1;
                    if (cnt == LEN_W'(1)) st <= info_q.dummy ? S_DUMMY : S_PLAN;
                end
                S_DUMMY: if (wr_valid) st <= S_PLAN;
                S_PLAN: begin
                    tx_n <= ptx; rx_n <= prx;
                    wrem <= wrem - LEN_W'(ptx); rrem <= rrem - LEN_W'(prx);
                    cnt  <= '0; wbuf <= '0;
                    st   <= (ptx != '0) ? S_GATHER : S_ISSUE;
                end
                S_GATHER: if (wr_valid) begin
                    wbuf[8*cnt[IW-1:0] +: 8] <= wr_data;
                    cnt <= cnt + 1'b1;
                    if (cnt + 1'b1 == LEN_W'(tx_n)) st <= S_ISSUE;
                end
                S_ISSUE: if (op_ready) st <= S_WAIT;
                S_WAIT: if (rsp_valid) begin
                    rxbuf <= rsp_data;
                    addr  <= addr + AW'(tx_n) + AW'(rx_n);
                    cnt   <= '0;
                    st    <= (rx_n != '0) ? S_EMIT : after_st;
                end
                S_EMIT: if (rd_ready) begin
                    rxbuf <= rxbuf >> 8;
                    cnt   <= cnt + 1'b1;
                    if (cnt + 1'b1 == LEN_W'(rx_n)) st <= after_st;
                end
                S_POLL:      if (op_ready)  st <= S_POLL_WAIT;
                S_POLL_WAIT: if (rsp_valid) st <= rsp_data[0] ? S_POLL : S_WREN;
                S_WREN:      if (op_ready)  st <= S_WREN_WAIT;
                S_WREN_WAIT: if (rsp_valid) st <= S_PLAN;
                S_DRAIN: if (wr_valid) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == LEN_W'(1)) st <= S_DONE;
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Stream handshakes and completion decoded from the state.
    always_comb begin
        req_ready = (st == S_IDLE);
        wr_ready  = (st == S_OPC) || (st == S_ADDR) || (st == S_DUMMY)
                    || (st == S_GATHER) || (st == S_DRAIN);
        rd_valid  = (st == S_EMIT);
        rd_data   = rxbuf[7:0];
        done      = (st == S_DONE);
        done_err  = (st == S_DONE) && err;
    end

    // Operation fields for data pieces, status polls and write-enables.
    always_comb begin
        op_valid = 1'b0; op_code = '0; op_addr = addr; op_alen = '0;
        op_wdata = '0;   op_txcnt = '0; op_rxcnt = '0;
        case (st)
            S_ISSUE: begin
                op_valid = 1'b1; op_code = info_q.issue; op_alen = info_q.acnt;
                op_wdata = wbuf; op_rxcnt = rx_n;
                op_txcnt = TCW'(1) + TCW'(info_q.acnt) + TCW'(tx_n);
            end
            S_POLL: begin
                op_valid = 1'b1; op_code = CMD_RDST; op_txcnt = TCW'(1); op_rxcnt = PW'(1);
            end
            S_WREN: begin
                op_valid = 1'b1; op_code = CMD_WREN; op_txcnt = TCW'(1);
            end
            default: ;
        endcase
    end

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable({op_code, op_addr, op_alen, op_wdata, op_txcnt, op_rxcnt})) // R11
        else $error("operation changed while waiting");
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)) // R11
        else $error("read byte changed while waiting");
    AST_PIECE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_rxcnt <= PW'(PIECE_MAX)) && (op_txcnt <= TCW'(1 + ADDR_BYTES + PIECE_MAX))) // R5
        else $error("operation exceeds piece size");
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !((op_txcnt > TCW'(op_alen) + TCW'(1)) && (op_rxcnt != '0))) // R9
        else $error("operation sends and receives data");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R10
        else $error("done longer than one cycle");
    AST_ENABLE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_POLL_WAIT) && rsp_valid && !rsp_data[0] |=> op_valid && (op_code == CMD_WREN) && (op_rxcnt == '0)) // R8
        else $error("write-enable did not follow idle status");
endmodule

// File: tb/spi_flash_sequencer_test.sv
module spi_flash_sequencer_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [7:0]  req_wlen = '0, req_rlen = '0;
    logic        wr_valid = 1'b0, wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid, rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        op_valid, op_ready = 1'b0;
    logic [7:0]  op_code;
    logic [23:0] op_addr;
    logic [1:0]  op_alen;
    logic [31:0] op_wdata;
    logic [3:0]  op_txcnt;
    logic [2:0]  op_rxcnt;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        done, done_err;

    spi_flash_sequencer uut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0]  wbuf [0:63];
    int          wlen = 0, widx = 0, req_pend = 0;
    logic [7:0]  lg_op [0:63];
    logic [23:0] lg_addr [0:63];
    logic [1:0]  lg_alen [0:63];
    logic [3:0]  lg_tx [0:63];
    logic [2:0]  lg_rx [0:63];
    logic [31:0] lg_wd [0:63];
    int          n_ops = 0, n_rd = 0, n_done = 0;
    logic [7:0]  rdbuf [0:63];
    logic        last_err = 1'b0;
    int          rsp_pend = 0, rsp_wait = 0, poll_left = 0, busy_cur = 0;
    logic [31:0] rsp_next = '0;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic int addr_cnt(input logic [7:0] c);
        return (c == 8'hD8 || c == 8'h03 || c == 8'h02 || c == 8'h0B || c == 8'hAB) ? 3 : 0;
    endfunction
    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Bench-side engine, streams and watchdog, all driven at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R10", "watchdog expired", cyc, 0);
            summary();
        end
        if (req_valid) req_valid = 1'b0;
        if (req_pend != 0) begin req_valid = 1'b1; req_pend = 0; end
        wr_valid = (widx < wlen) && ($urandom % 4 != 0);
        wr_data  = (widx < wlen) ? wbuf[widx] : 8'h00;
        if (wr_valid && wr_ready) widx++;
        if (rsp_valid) rsp_valid = 1'b0;
        else if (rsp_pend != 0) begin
            if (rsp_wait <= 1) begin rsp_valid = 1'b1; rsp_data = rsp_next; rsp_pend = 0; end
            else rsp_wait--;
        end
        op_ready = ($urandom % 2 == 0);   // throttling exercises R11 holds
        if (op_valid && op_ready && n_ops < 64) begin
            lg_op[n_ops] = op_code; lg_addr[n_ops] = op_addr; lg_alen[n_ops] = op_alen;
            lg_tx[n_ops] = op_txcnt; lg_rx[n_ops] = op_rxcnt; lg_wd[n_ops] = op_wdata;
            n_ops++;
            if (op_code == 8'h05) begin
                if (poll_left > 0) begin rsp_next = 32'h81; poll_left--; end
                else begin rsp_next = 32'h80; poll_left = busy_cur; end
            end else
                for (int i = 0; i < 4; i++) rsp_next[8*i +: 8] = mem_byte(op_addr + 24'(i));
            rsp_pend = 1; rsp_wait = 1 + ($urandom % 3);
        end
        rd_ready = ($urandom % 3 != 0);
        if (rd_valid && rd_ready && n_rd < 64) begin rdbuf[n_rd] = rd_data; n_rd++; end
        if (done) begin n_done++; last_err = done_err; end
    end

    task automatic chk_op(input int k, input logic [7:0] c, input logic [1:0] al, input int tx,
                          input int rx, input bit data, input logic [23:0] a, input logic [31:0] wd,
                          input string tag);
        if (k >= n_ops) begin chk(1'b0, tag, "missing operation", n_ops, k + 1); return; end
        chk(lg_op[k] == c && lg_alen[k] == al && int'(lg_tx[k]) == tx && int'(lg_rx[k]) == rx,
            tag, "operation code/alen/tx/rx", {lg_op[k], 2'b0, lg_alen[k], lg_tx[k], 1'b0, lg_rx[k]},
            {c, 2'b0, al, 4'(tx), 1'b0, 3'(rx)});
        if (data) begin
            chk(lg_addr[k] == a, "R6", "piece address", lg_addr[k], a);
            chk(lg_wd[k] == wd, "R5", "piece write data", lg_wd[k], wd);
        end
    endtask

    task automatic run_req(input logic [7:0] c, input logic [23:0] a0, input int nd, input int nr,
                           input int busyn, input bit exp_err, input string tag);
        int ac, hdr, d0, k, di, wrem, rrem, tx, rx, bad;
        logic [23:0] a;
        logic [31:0] wd;
        ac  = addr_cnt(c);
        hdr = ac + ((c == 8'h0B) ? 1 : 0);
        @(posedge clk);
        wbuf[0] = c;
        for (int i = 0; i < 3; i++) wbuf[1 + i] = a0[8*(2-i) +: 8];
        if (c == 8'h0B) wbuf[4] = 8'hEE;
        for (int i = 0; i < 40; i++) wbuf[1 + hdr + i] = 8'($urandom);
        wlen = 1 + hdr + nd; widx = 0; n_ops = 0; n_rd = 0;
        busy_cur = busyn; poll_left = busyn;
        req_wlen = 8'(wlen); req_rlen = 8'(nr);
        d0 = n_done; req_pend = 1;
        while (n_done == d0) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(n_done == d0 + 1, "R10", "one completion pulse", n_done - d0, 1);
        chk(last_err == exp_err, exp_err ? "R9" : "R10", "completion error flag", last_err, exp_err);
        if (exp_err) begin
            chk(n_ops == 0, "R9", "operations on refused request", n_ops, 0);
            chk(widx == wlen, "R9", "write bytes consumed", widx, wlen);
            return;
        end
        a = (ac != 0) ? a0 : 24'h0;
        wrem = nd; rrem = nr; k = 0; di = 0;
        forever begin
            tx = imin(wrem, 4); rx = imin(rrem, 4); wd = '0;
            for (int i = 0; i < tx; i++) wd[8*i +: 8] = wbuf[1 + hdr + di + i];
            chk_op(k, (c == 8'h0B) ? 8'h03 : c, 2'(ac), 1 + ac + tx, rx, 1'b1, a, wd, tag);
            k++; di += tx; wrem -= tx; rrem -= rx; a += 24'(tx + rx);
            if (wrem == 0 && rrem == 0) break;
            if (c == 8'h02) begin
                for (int p = 0; p <= busyn; p++) begin
                    chk_op(k, 8'h05, 2'd0, 1, 1, 1'b0, '0, '0, "R8"); k++;
                end
                chk_op(k, 8'h06, 2'd0, 1, 0, 1'b0, '0, '0, "R8"); k++;
            end
        end
        chk(n_ops == k, tag, "operation count", n_ops, k);
        bad = 0;
        for (int i = 0; i < nr && i < n_rd; i++)
            if (rdbuf[i] !== ((c == 8'h05) ? 8'h80 : mem_byte(((ac != 0) ? a0 : 24'h0) + 24'(i)))) bad++;
        chk(n_rd == nr && bad == 0, "R7 R11", "read stream bytes/mismatches", {n_rd, bad}, {nr, 0});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !op_valid && !wr_ready && !rd_valid && !done, "R1", "reset outputs",
            {req_ready, op_valid, wr_ready, rd_valid, done}, 5'b10000);
        run_req(8'h06, 24'h0, 0, 0, 0, 1'b0, "R2");
        run_req(8'h04, 24'h0, 0, 0, 0, 1'b0, "R2");
        run_req(8'hC7, 24'h0, 0, 0, 0, 1'b0, "R2");
        run_req(8'h9F, 24'h0, 0, 3, 0, 1'b0, "R2");
        run_req(8'h05, 24'h0, 0, 1, 0, 1'b0, "R2");
        run_req(8'h01, 24'h0, 1, 0, 0, 1'b0, "R2");
        run_req(8'hAB, 24'h123456, 0, 1, 0, 1'b0, "R3");
        run_req(8'hD8, 24'hABCDEF, 0, 0, 0, 1'b0, "R3");
        run_req(8'h03, 24'h00FFFE, 0, 9, 0, 1'b0, "R5");
        run_req(8'h0B, 24'h345678, 0, 5, 0, 1'b0, "R4");
        run_req(8'h02, 24'h001000, 4, 0, 2, 1'b0, "R8");
        run_req(8'h02, 24'h002000, 9, 0, 1, 1'b0, "R8");
        run_req(8'h02, 24'h003000, 0, 0, 0, 1'b0, "R5");
        run_req(8'h55, 24'h0, 3, 0, 0, 1'b1, "R9");
        run_req(8'h03, 24'h000100, 2, 2, 0, 1'b1, "R9");
        run_req(8'h9F, 24'h0, 0, 2, 0, 1'b1, "R9");
        run_req(8'h03, 24'h000100, -2, 4, 0, 1'b1, "R9");
        run_req(8'h03, 24'h0, -4, 0, 0, 1'b1, "R9");
        for (int n = 0; n < 24; n++) begin
            int sel;
            sel = $urandom % 3;
            if (sel == 0)      run_req(8'h03, 24'($urandom), 0, $urandom % 14, 0, 1'b0, "R6");
            else if (sel == 1) run_req(8'h0B, 24'($urandom), 0, $urandom % 14, 0, 1'b0, "R4");
            else               run_req(8'h02, 24'($urandom), $urandom % 14, 0, $urandom % 3, 1'b0, "R8");
        end
        summary();
    end
endmodule